// File: doc/BRIEF.md
# Real-Time Clock Counter Chain

This block keeps time of day from a slow 32.768 kHz clock. A fractional divider turns the slow clock into a 100 Hz step. The step drives four cascaded counters: hundredths of a second, seconds, minutes and hours. The hour counter wraps either after 23 or after 255, chosen by a mode bit. Each hour wrap is a midnight event. The event sets a sticky flag, raises a one-cycle wake pulse in the slow domain, and sets an interrupt pending flag in the host domain. The wake pulse can rouse a sleeping processor whose clock is stopped.

The host reads the counters while they run. The counters are not frozen for a read, so software re-reads the whole set whenever the hundredths value changes between the start and the end of a read sequence. Host writes to the counters and to the control register are captured in the host domain. A toggle handshake carries each write into the slow domain. Counting can be stopped and started through an enable bit, and the time is normally preset while the clock is stopped.

Top module: `rtc_timekeeper`

## Requirements
- R1: While enabled, the hundredths counter (register 1) steps 0 to 99, seconds (register 2) 0 to 59 and minutes (register 3) 0 to 59. A counter at or above its top wraps to 0 on its next step and passes a carry on in the same slow-clock cycle.
- R2: With control bit 1 clear, the hour counter (register 4) wraps to 0 from 23 or any larger value. With control bit 1 set, it wraps from 255 only, so 23 advances to 24.
- R3: Every hour wrap sets the sticky midnight flag (control bit 2) and drives `wake` high for exactly one slow-clock cycle.
- R4: Writing the control register with bit 2 set clears the midnight flag, and writing it with bit 2 clear leaves the flag alone. An hour wrap in the same slow cycle as a clear keeps the flag set.
- R5: Every hour wrap sets `irq_pending`. It stays set while `irq_enable` is low. `irq_req` equals `irq_pending` AND `irq_enable`, and a one-cycle `irq_vector` pulse clears the pending flag.
- R6: A host write becomes visible in the slow domain no later than the second rising slow-clock edge after the host edge that sampled it. Consecutive writes are at least three slow-clock periods apart.
- R7: Control bit 0 is the enable. While it is clear, all counters and the divider phase hold. A counter write made while stopped is still applied.
- R8: The divider adds OUT_HZ each enabled slow cycle and steps the hundredths when the sum reaches TICK_HZ, keeping the remainder. A write to any time counter clears the divider phase. With TICK_HZ=750 and OUT_HZ=100, the hundredths intervals are 8, 7, 8, 7 slow cycles from a cleared phase.
- R9: A read strobe loads `host_rdata` on the next host edge. Address 0 reads {5'b0, flag, mode, enable}, and addresses 1 to 4 read hundredths, seconds, minutes and hours. Other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_host | input | 1 | Host bus clock |
| rst_host_n | input | 1 | Synchronous active-low reset, host domain |
| clk_rtc | input | 1 | 32.768 kHz counter clock |
| rst_rtc_n | input | 1 | Synchronous active-low reset, slow domain |
| host_wr_en | input | 1 | Write strobe |
| host_addr | input | 3 | Register address for read or write |
| host_wdata | input | 8 | Write data |
| host_rd_en | input | 1 | Read strobe |
| host_rdata | output | 8 | Registered read data |
| irq_enable | input | 1 | Interrupt enable from the interrupt controller |
| irq_vector | input | 1 | Pulse when the interrupt is serviced |
| irq_req | output | 1 | Interrupt request (pending and enabled) |
| irq_pending | output | 1 | Pending midnight interrupt |
| wake | output | 1 | One slow-cycle wake pulse per hour wrap |

## Verification
The assertions check, on every cycle, that a counter below its top steps by exactly one, that the divider phase stays below TICK_HZ, and that a stopped chain holds its value. They also check that a wrap leaves the hour at zero and the flag set even against a simultaneous clear, that the flag falls only after a write-one, that the wake pulse coincides with the flag, and that the pending flag follows set and service. Other behaviour shows only in the bench's scenarios: the two-edge write latency, the 8/7 interval pattern of the fractional divider, the rollover of the full chain in both hour modes, out-of-range presets, and the holding of a pending interrupt while it is disabled.

// File: rtl/rtc_tk_pkg.sv
// Shared constants and register selectors for the real-time clock counter chain.
// Assumes an 8-bit host data path and a 3-bit register address.
package rtc_tk_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int NSTAGE = 4;      // hundredths, seconds, minutes, hours

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_HUND = 3'd1,
        REG_SEC  = 3'd2,
        REG_MIN  = 3'd3,
        REG_HOUR = 3'd4
    } reg_sel_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MODE_BIT = 1;
    localparam int CTRL_FLAG_BIT = 2;
endpackage

// File: rtl/rtc_frac_div.sv
// Fractional divider: emits one step per TICK_HZ/OUT_HZ slow cycles on average.
// Assumes OUT_HZ <= TICK_HZ. The phase holds while run is low and clears on restart.
module rtc_frac_div #(
    parameter int TICK_HZ = 32768,
    parameter int OUT_HZ  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int ACC_W = $clog2(TICK_HZ) + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(OUT_HZ);
    localparam logic [ACC_W-1:0] LIM  = ACC_W'(TICK_HZ);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;

    // Next phase and the step decision
    always_comb begin
        sum  = acc + STEP;
        tick = run && (sum >= LIM);
    end

    // Phase accumulator: clear, hold or advance keeping the remainder
    always_ff @(posedge clk) begin
        if (!rst_n)       acc <= '0;
        else if (restart) acc <= '0;
        else if (run)     acc <= tick ? (sum - LIM) : sum;
    end

    assert_phase_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc < LIM);
endmodule

// File: rtl/rtc_count_stage.sv
// One wrapping counter of the chain. It steps when step is high and wraps to 0
// when at or above wrap_at, raising carry_out in the same cycle. A load takes priority.
module rtc_count_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         step,
    input  logic [W-1:0] wrap_at,
    output logic [W-1:0] value,
    output logic         carry_out
);
    // Carry to the next stage on the step that wraps this one
    always_comb carry_out = step && (value >= wrap_at);

    // Counter register: load, wrap or increment
    always_ff @(posedge clk) begin
        if (!rst_n)         value <= '0;
        else if (ld)        value <= ld_val;
        else if (carry_out) value <= '0;
        else if (step)      value <= value + 1'b1;
    end

    assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && (value < wrap_at)) |=> (value == $past(value) + 1'b1));
    assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && (value >= wrap_at)) |=> (value == '0));
endmodule

// File: rtl/rtc_time_chain.sv
// Cascade of hundredths, seconds, minutes and hours counters. The hour wrap
// point follows hour_long (255 when set, DAY_HOUR_TOP when clear). midnight is
// the hour stage carry.
module rtc_time_chain
    import rtc_tk_pkg::*;
#(
    parameter int HUND_TOP     = 99,
    parameter int SEC_TOP      = 59,
    parameter int MIN_TOP      = 59,
    parameter int DAY_HOUR_TOP = 23
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic [NSTAGE-1:0]             ld,
    input  logic [DATA_W-1:0]             ld_val,
    input  logic                          hour_long,
    output logic [NSTAGE-1:0][DATA_W-1:0] counts,
    output logic                          midnight
);
    logic [DATA_W-1:0] wrap_at [NSTAGE];
    logic [NSTAGE-1:0] step;
    logic [NSTAGE-1:0] carry;

    // Wrap point of each stage; only the hour stage depends on the mode
    always_comb begin
        wrap_at[0] = DATA_W'(HUND_TOP);
        wrap_at[1] = DATA_W'(SEC_TOP);
        wrap_at[2] = DATA_W'(MIN_TOP);
        wrap_at[3] = hour_long ? {DATA_W{1'b1}} : DATA_W'(DAY_HOUR_TOP);
    end

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign step[g] = tick;
        end else begin : g_next
            assign step[g] = carry[g-1];
        end
        rtc_count_stage #(.W(DATA_W)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld        (ld[g]),
            .ld_val    (ld_val),
            .step      (step[g]),
            .wrap_at   (wrap_at[g]),
            .value     (counts[g]),
            .carry_out (carry[g])
        );
    end

    assign midnight = carry[NSTAGE-1];

    assert_hour_zero_after_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (midnight && !ld[NSTAGE-1]) |=> (counts[NSTAGE-1] == '0));
endmodule

// File: rtl/rtc_wr_xfer.sv
// Carries host writes into the slow domain. The host side holds address and data
// and flips a request toggle. The slow side applies the write on the edge at which
// the first synchroniser stage differs from the second, which is at most two slow
// edges after the host edge. Assumes writes are spaced by at least three slow periods.
module rtc_wr_xfer #(
    parameter int AW = 3,
    parameter int DW = 8
) (
    input  logic          clk_host,
    input  logic          rst_host_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          clk_rtc,
    input  logic          rst_rtc_n,
    output logic          apply,
    output logic [AW-1:0] apply_addr,
    output logic [DW-1:0] apply_data
);
    logic          req_tog;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;
    logic          sync1, sync2;

    // Host side: capture the write and flip the request toggle
    always_ff @(posedge clk_host) begin
        if (!rst_host_n) begin
            req_tog   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
        end else if (wr_en) begin
            req_tog   <= ~req_tog;
            hold_addr <= wr_addr;
            hold_data <= wr_data;
        end
    end

    // Slow side: two-stage toggle tracking
    always_ff @(posedge clk_rtc) begin
        if (!rst_rtc_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= req_tog;
            sync2 <= sync1;
        end
    end

    assign apply      = sync1 ^ sync2;
    assign apply_addr = hold_addr;
    assign apply_data = hold_data;

    assert_single_apply_R6: assert property (@(posedge clk_rtc) disable iff (!rst_rtc_n)
        apply |=> (sync2 == $past(sync1)));
endmodule

// File: rtl/rtc_event_sync.sv
// Carries the midnight event from the slow domain into a host-domain pending flag.
// Set wins over a simultaneous service pulse. Assumes events are far apart
// compared with three host cycles.
module rtc_event_sync (
    input  logic clk_rtc,
    input  logic rst_rtc_n,
    input  logic event_in,
    input  logic clk_host,
    input  logic rst_host_n,
    input  logic ack,
    output logic pending
);
    logic ev_tog;
    logic h1, h2, h3;
    logic set_p;

    // Slow side: flip the event toggle on each event
    always_ff @(posedge clk_rtc) begin
        if (!rst_rtc_n)    ev_tog <= 1'b0;
        else if (event_in) ev_tog <= ~ev_tog;
    end

    // Host side: synchronise the toggle and keep one delayed copy
    always_ff @(posedge clk_host) begin
        if (!rst_host_n) begin
            h1 <= 1'b0;
            h2 <= 1'b0;
            h3 <= 1'b0;
        end else begin
            h1 <= ev_tog;
            h2 <= h1;
            h3 <= h2;
        end
    end

    assign set_p = h2 ^ h3;

    // Pending flag: set by an event, cleared by service
    always_ff @(posedge clk_host) begin
        if (!rst_host_n) pending <= 1'b0;
        else if (set_p)  pending <= 1'b1;
        else if (ack)    pending <= 1'b0;
    end

    assert_pending_set_R5: assert property (@(posedge clk_host) disable iff (!rst_host_n)
        set_p |=> pending);
    assert_pending_service_R5: assert property (@(posedge clk_host) disable iff (!rst_host_n)
        (!set_p && ack) |=> !pending);
    assert_pending_hold_R5: assert property (@(posedge clk_host) disable iff (!rst_host_n)
        (pending && !ack) |=> pending);
endmodule

// File: rtl/rtc_timekeeper.sv
// Real-time clock counter chain top. It holds the slow-domain control state
// (enable, hour mode, midnight flag, wake), the divider and the counter chain, the
// write crossing, the event crossing and the registered host read port.
// Assumes host reads of running counters are repeated by software when the
// hundredths value moves during a read sequence.
module rtc_timekeeper
    import rtc_tk_pkg::*;
#(
    parameter int TICK_HZ      = 32768,
    parameter int OUT_HZ       = 100,
    parameter int HUND_TOP     = 99,
    parameter int SEC_TOP      = 59,
    parameter int MIN_TOP      = 59,
    parameter int DAY_HOUR_TOP = 23
) (
    input  logic       clk_host,
    input  logic       rst_host_n,
    input  logic       clk_rtc,
    input  logic       rst_rtc_n,
    input  logic       host_wr_en,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       host_rd_en,
    output logic [7:0] host_rdata,
    input  logic       irq_enable,
    input  logic       irq_vector,
    output logic       irq_req,
    output logic       irq_pending,
    output logic       wake
);
    logic                          apply;
    logic [ADDR_W-1:0]             ap_addr;
    logic [DATA_W-1:0]             ap_data;
    logic                          ctrl_wr;
    logic [NSTAGE-1:0]             time_ld;
    logic                          any_ld;
    logic                          en_q, mode_q, flag_q, wake_q;
    logic                          tick;
    logic                          midnight;
    logic [NSTAGE-1:0][DATA_W-1:0] counts;
    logic [DATA_W-1:0]             rd_mux;

    rtc_wr_xfer #(.AW(ADDR_W), .DW(DATA_W)) u_xfer (
        .clk_host   (clk_host),
        .rst_host_n (rst_host_n),
        .wr_en      (host_wr_en),
        .wr_addr    (host_addr),
        .wr_data    (host_wdata),
        .clk_rtc    (clk_rtc),
        .rst_rtc_n  (rst_rtc_n),
        .apply      (apply),
        .apply_addr (ap_addr),
        .apply_data (ap_data)
    );

    assign ctrl_wr = apply && (ap_addr == REG_CTRL);

    for (genvar g = 0; g < NSTAGE; g++) begin : g_ld
        assign time_ld[g] = apply && (int'(ap_addr) == int'(REG_HUND) + g);
    end
    assign any_ld = |time_ld;

    // Enable and hour mode written through the control register
    always_ff @(posedge clk_rtc) begin
        if (!rst_rtc_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q   <= ap_data[CTRL_EN_BIT];
            mode_q <= ap_data[CTRL_MODE_BIT];
        end
    end

    // Sticky midnight flag: the event beats a write-one clear
    always_ff @(posedge clk_rtc) begin
        if (!rst_rtc_n)                          flag_q <= 1'b0;
        else if (midnight)                       flag_q <= 1'b1;
        else if (ctrl_wr && ap_data[CTRL_FLAG_BIT]) flag_q <= 1'b0;
    end

    // One-cycle wake pulse following each event
    always_ff @(posedge clk_rtc) begin
        if (!rst_rtc_n) wake_q <= 1'b0;
        else            wake_q <= midnight;
    end

    rtc_frac_div #(.TICK_HZ(TICK_HZ), .OUT_HZ(OUT_HZ)) u_div (
        .clk     (clk_rtc),
        .rst_n   (rst_rtc_n),
        .run     (en_q && !any_ld),
        .restart (any_ld),
        .tick    (tick)
    );

    rtc_time_chain #(
        .HUND_TOP     (HUND_TOP),
        .SEC_TOP      (SEC_TOP),
        .MIN_TOP      (MIN_TOP),
        .DAY_HOUR_TOP (DAY_HOUR_TOP)
    ) u_chain (
        .clk       (clk_rtc),
        .rst_n     (rst_rtc_n),
        .tick      (tick),
        .ld        (time_ld),
        .ld_val    (ap_data),
        .hour_long (mode_q),
        .counts    (counts),
        .midnight  (midnight)
    );

    rtc_event_sync u_evt (
        .clk_rtc    (clk_rtc),
        .rst_rtc_n  (rst_rtc_n),
        .event_in   (midnight),
        .clk_host   (clk_host),
        .rst_host_n (rst_host_n),
        .ack        (irq_vector),
        .pending    (irq_pending)
    );

    assign irq_req = irq_pending && irq_enable;
    assign wake    = wake_q;

    // Read selection from the live slow-domain state
    always_comb begin
        rd_mux = '0;
        case (host_addr)
            REG_CTRL: begin
                rd_mux[CTRL_EN_BIT]   = en_q;
                rd_mux[CTRL_MODE_BIT] = mode_q;
                rd_mux[CTRL_FLAG_BIT] = flag_q;
            end
            REG_HUND: rd_mux = counts[0];
            REG_SEC:  rd_mux = counts[1];
            REG_MIN:  rd_mux = counts[2];
            REG_HOUR: rd_mux = counts[3];
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data, loaded on the read strobe
    always_ff @(posedge clk_host) begin
        if (!rst_host_n)     host_rdata <= '0;
        else if (host_rd_en) host_rdata <= rd_mux;
    end

    assert_freeze_R7: assert property (@(posedge clk_rtc) disable iff (!rst_rtc_n)
        (!en_q && !any_ld) |=> $stable(counts));
    assert_flag_on_event_R3: assert property (@(posedge clk_rtc) disable iff (!rst_rtc_n)
        midnight |=> flag_q);
    assert_flag_clear_only_by_write_R4: assert property (@(posedge clk_rtc) disable iff (!rst_rtc_n)
        (flag_q && !(ctrl_wr && ap_data[CTRL_FLAG_BIT])) |=> flag_q);
    assert_wake_with_flag_R3: assert property (@(posedge clk_rtc) disable iff (!rst_rtc_n)
        wake_q |-> flag_q);
    assert_wake_single_R3: assert property (@(posedge clk_rtc) disable iff (!rst_rtc_n)
        wake_q |=> !wake_q);
endmodule

// File: tb/rtc_timekeeper_tb_top.sv
// Directed bench for the real-time clock counter chain: one task per scenario.
module rtc_timekeeper_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RTC_PERIOD = 4 * CLK_PERIOD;
    localparam int WATCHDOG   = 150000;

    logic       clk_host = 1'b0;
    logic       clk_rtc  = 1'b0;
    logic       rst_host_n = 1'b0;
    logic       rst_rtc_n  = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [2:0] host_addr  = '0;
    logic [7:0] host_wdata = '0;
    logic       host_rd_en = 1'b0;
    logic [7:0] host_rdata;
    logic       irq_enable = 1'b0;
    logic       irq_vector = 1'b0;
    logic       irq_req, irq_pending, wake;

    int checks = 0;
    int fails  = 0;
    int rtc_edges = 0;
    int wake_cnt  = 0;
    int wake_lvl  = 0;

    always #(CLK_PERIOD/2) clk_host = ~clk_host;
    always #(RTC_PERIOD/2) clk_rtc  = ~clk_rtc;

    always @(posedge clk_rtc) rtc_edges++;
    always @(negedge clk_rtc) begin
        if (wake) wake_lvl++;
        if (wake && wake_lvl == 1) wake_cnt++;
        if (!wake) wake_lvl = 0;
    end

    rtc_timekeeper #(.TICK_HZ(750), .OUT_HZ(100)) dut_i (
        .clk_host    (clk_host),
        .rst_host_n  (rst_host_n),
        .clk_rtc     (clk_rtc),
        .rst_rtc_n   (rst_rtc_n),
        .host_wr_en  (host_wr_en),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rd_en  (host_rd_en),
        .host_rdata  (host_rdata),
        .irq_enable  (irq_enable),
        .irq_vector  (irq_vector),
        .irq_req     (irq_req),
        .irq_pending (irq_pending),
        .wake        (wake)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk_host);
        host_wr_en = 1'b1; host_addr = 3'(a); host_wdata = 8'(d);
        @(negedge clk_host);
        host_wr_en = 1'b0;
        repeat (3) @(posedge clk_rtc);
        @(negedge clk_host);
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk_host);
        host_rd_en = 1'b1; host_addr = 3'(a);
        @(negedge clk_host);
        host_rd_en = 1'b0;
        d = int'(host_rdata);
    endtask

    // Poll the hundredths until they move; returns the slow edge count at detection
    task automatic wait_hund_move(output int at_edge);
        int first, cur;
        rd(1, first);
        cur = first;
        at_edge = -1;
        for (int i = 0; i < 2000 && cur == first; i++) rd(1, cur);
        if (cur != first) at_edge = rtc_edges;
    endtask

    task automatic preset(input int h, input int m, input int s, input int c);
        wr(4, h); wr(3, m); wr(2, s); wr(1, c);
    endtask

    task automatic t_reset();
        int v;
        for (int a = 0; a < 5; a++) begin
            rd(a, v);
            chk("R9 reset register value", v, 0);
        end
        chk("R5 reset irq_pending", int'(irq_pending), 0);
        chk("R3 reset wake", int'(wake), 0);
    endtask

    task automatic t_write_latency();
        int v;
        @(negedge clk_host);
        host_wr_en = 1'b1; host_addr = 3'd2; host_wdata = 8'd42;
        @(posedge clk_host);
        #1 host_wr_en = 1'b0;
        repeat (2) @(posedge clk_rtc);
        #1;
        rd(2, v);
        chk("R6 seconds visible after two slow edges", v, 42);
        repeat (3) @(posedge clk_rtc);
    endtask

    task automatic t_carry();
        int v, e;
        preset(5, 59, 59, 99);
        wr(0, 1);
        wait_hund_move(e);
        chk("R1 rollover detected", int'(e >= 0), 1);
        rd(1, v); chk("R1 hundredths wrap", v, 0);
        rd(2, v); chk("R1 seconds wrap", v, 0);
        rd(3, v); chk("R1 minutes wrap", v, 0);
        rd(4, v); chk("R1 hour carry in", v, 6);
        rd(0, v); chk("R3 no flag without hour wrap", v, 1);
        chk("R3 no wake without hour wrap", wake_cnt, 0);
        wr(0, 0);
        // out-of-range seconds still wrap and carry
        preset(2, 10, 75, 99);
        wr(0, 1);
        wait_hund_move(e);
        rd(2, v); chk("R1 out-of-range seconds wrap", v, 0);
        rd(3, v); chk("R1 out-of-range carry to minutes", v, 11);
        wr(0, 0);
    endtask

    task automatic t_divider();
        int e0, e1;
        preset(1, 0, 0, 0);
        wr(0, 1);
        wait_hund_move(e0);
        for (int i = 0; i < 4; i++) begin
            wait_hund_move(e1);
            chk("R8 hundredths interval", e1 - e0, (i % 2 == 0) ? 7 : 8);
            e0 = e1;
        end
        wr(0, 0);
    endtask

    task automatic t_freeze();
        int a, b;
        preset(3, 4, 5, 6);
        wr(0, 1);
        repeat (30) @(posedge clk_rtc);
        wr(0, 0);
        rd(1, a);
        repeat (40) @(posedge clk_rtc);
        rd(1, b);
        chk("R7 hundredths hold while stopped", b, a);
        wr(3, 7);
        rd(3, b);
        chk("R7 write applied while stopped", b, 7);
    endtask

    task automatic t_midnight_short();
        int v, e;
        preset(23, 59, 59, 99);
        wr(0, 1);
        wait_hund_move(e);
        wr(0, 0);
        rd(4, v); chk("R2 short mode 23 wraps to 0", v, 0);
        rd(0, v); chk("R3 midnight flag set", v, 4);
        chk("R3 one wake pulse", wake_cnt, 1);
        chk("R5 irq_pending after wrap", int'(irq_pending), 1);
        // larger than 23 also wraps in short mode
        preset(40, 59, 59, 99);
        wr(0, 1);
        wait_hund_move(e);
        wr(0, 0);
        rd(4, v); chk("R2 short mode 40 wraps to 0", v, 0);
        chk("R3 second wake pulse", wake_cnt, 2);
    endtask

    task automatic t_flag_clear();
        int v;
        wr(0, 0);
        rd(0, v); chk("R4 write 0 to flag keeps it", v, 4);
        wr(0, 4);
        rd(0, v); chk("R4 write 1 to flag clears it", v, 0);
    endtask

    task automatic t_irq();
        irq_enable = 1'b0;
        repeat (50) @(posedge clk_host);
        @(negedge clk_host);
        chk("R5 pending held while disabled", int'(irq_pending), 1);
        chk("R5 no request while disabled", int'(irq_req), 0);
        irq_enable = 1'b1;
        #1;
        chk("R5 request when enabled", int'(irq_req), 1);
        @(negedge clk_host);
        irq_vector = 1'b1;
        @(negedge clk_host);
        irq_vector = 1'b0;
        chk("R5 service clears pending", int'(irq_pending), 0);
        chk("R5 request drops after service", int'(irq_req), 0);
    endtask

    task automatic t_midnight_long();
        int v, e;
        preset(23, 59, 59, 99);
        wr(0, 3);
        wait_hund_move(e);
        wr(0, 2);
        rd(4, v); chk("R2 long mode 23 advances to 24", v, 24);
        rd(0, v); chk("R3 no flag at 23 in long mode", v, 2);
        preset(255, 59, 59, 99);
        wr(0, 3);
        wait_hund_move(e);
        wr(0, 2);
        rd(4, v); chk("R2 long mode 255 wraps to 0", v, 0);
        rd(0, v); chk("R3 flag set in long mode", v, 6);
        chk("R5 pending again after long wrap", int'(irq_pending), 1);
    endtask

    task automatic t_bad_addr();
        int v;
        wr(6, 8'h5A);
        rd(6, v); chk("R9 unmapped address reads 0", v, 0);
        rd(3, v); chk("R9 unmapped write leaves minutes", v, 0);
        rd(0, v); chk("R9 unmapped write leaves control", v, 6);
    endtask

    initial begin
        repeat (4) @(posedge clk_rtc);
        @(negedge clk_host);
        rst_host_n = 1'b1;
        rst_rtc_n  = 1'b1;
        repeat (2) @(posedge clk_rtc);
        t_reset();
        t_write_latency();
        t_carry();
        t_divider();
        t_freeze();
        t_midnight_short();
        t_flag_clear();
        t_irq();
        t_midnight_long();
        t_bad_addr();
        summary();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk_host);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule